// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in a small direct-mapped, write-back cache that sits on a shared snooping bus. Each line holds a tag and one of four states: Modified, Exclusive, Shared or Invalid. The block serves processor reads and writes. On a miss it issues read, read-for-ownership or writeback commands. A write to a Shared line gets a dataless upgrade command. The block also answers other caches' bus commands in the same cycle they appear.

A request that hits completes in the cycle it is presented. A request that needs the bus holds the processor until the grant arrives and, where data moves, until the data-valid handshake ends. Snooped commands update the line state at the next clock edge. The shared and flush responses are combinational. The data array, bus arbitration and the memory model sit outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, and no snoop gets a shared or flush response.
- R2: A read miss issues command READ (code 0) for the request address. At the data-valid cycle the line enters Exclusive if bus_shared_in is low, and Shared if it is high.
- R3: A write miss issues READX (code 1). The line ends Modified when data-valid arrives.
- R4: A write to a Shared line issues UPGR (code 2). It completes in the grant cycle with no data phase, and the line becomes Modified.
- R5: A write to an Exclusive line completes at once with no bus command and makes the line Modified. A write to a Modified line also completes at once and stays Modified.
- R6: A read that hits in M, E or S, and a silent write hit, raise cpu_ready in the same cycle with no bus command. A miss keeps cpu_ready low and holds bus_req_valid and the command steady until bus_grant.
- R7: A Modified line that snoops READ asserts snoop_flush and snoop_shared and moves to Shared. On a snooped READX it asserts snoop_flush and moves to Invalid.
- R8: An E or S line that snoops READ asserts snoop_shared without flush and ends Shared. E and S lines go to Invalid without flush on READX or UPGR. A snooped WRBACK (code 3), or a snoop that misses, gives no response and changes no state.
- R9: A conflict miss on a Modified victim first issues WRBACK with the victim's address, then the fill command. Replacing an E or S victim issues only the fill.
- R10: While idle, a processor request whose index equals that of a valid snoop in the same cycle is stalled for that cycle: cpu_ready stays low and no bus command starts.
- R11: If a snoop invalidates a line while its upgrade is still waiting for grant, the pending command becomes READX. The write then completes through a data fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address (index in low bits, tag above) |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req_valid | output | 1 | Bus command requested |
| bus_req_cmd | output | 2 | 0 READ, 1 READX, 2 UPGR, 3 WRBACK |
| bus_req_addr | output | ADDR_W | Line address of the bus command |
| bus_grant | input | 1 | Bus grants the pending command |
| bus_data_valid | input | 1 | Data phase of the granted command ends |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at data-valid) |
| snoop_valid | input | 1 | Snooped bus command present |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared | output | 1 | This cache holds the snooped line (READ only) |
| snoop_flush | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The bench walks one line through every state and checks each transition at the ports. Where a state cannot be seen directly, a later snoop or request exposes it. A design that skipped the silent E-to-M write would show no flush on the next snooped read. A design that treated a Shared victim like a dirty one would issue a spurious writeback. The bench also stages two races. In the first, a processor request and a snoop hit the same index in one cycle; a design without the stall would let the write's upgrade start at once. In the second, an upgrade loses its line to a snooped READX before grant; a design that kept the upgrade would become Modified without fetching data.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LN_I = 2'b00,
      LN_S = 2'b01,
      LN_E = 2'b10,
      LN_M = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_RD  = 2'd0,
      CMD_RDX = 2'd1,
      CMD_UPG = 2'd2,
      CMD_WB  = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_DATA = 2'd2
   } seq_st_t;

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
   import mesi_pkg::*;
#(
   parameter int INDEX_W = 3,
   parameter int TAG_W   = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_a_idx,
   output line_st_t           rd_a_st,
   output logic [TAG_W-1:0]   rd_a_tag,
   input  logic [INDEX_W-1:0] rd_b_idx,
   output line_st_t           rd_b_st,
   output logic [TAG_W-1:0]   rd_b_tag,
   input  logic               fw_en,
   input  logic [INDEX_W-1:0] fw_idx,
   input  logic [TAG_W-1:0]   fw_tag,
   input  line_st_t           fw_st,
   input  logic               sw_en,
   input  logic [INDEX_W-1:0] sw_idx,
   input  line_st_t           sw_st
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINES-1:0][1:0]       st_vec;
   logic [LINES-1:0][TAG_W-1:0] tag_vec;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t         st_q;
      logic [TAG_W-1:0] tag_q;
      logic             fw_hit;
      logic             sw_hit;

      assign fw_hit = fw_en && (fw_idx == INDEX_W'(g));
      assign sw_hit = sw_en && (sw_idx == INDEX_W'(g));

      // the local sequencer's write wins over a snoop write on the same line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st_q <= LN_I;
         else if (fw_hit) st_q <= fw_st;
         else if (sw_hit) st_q <= sw_st;
      end

      always_ff @(posedge clk) begin
         if (fw_hit) tag_q <= fw_tag;
      end

      assign st_vec[g]  = st_q;
      assign tag_vec[g] = tag_q;
   end

   assign rd_a_st  = line_st_t'(st_vec[rd_a_idx]);
   assign rd_a_tag = tag_vec[rd_a_idx];
   assign rd_b_st  = line_st_t'(st_vec[rd_b_idx]);
   assign rd_b_tag = tag_vec[rd_b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W = 13
) (
   input  logic             sn_valid,
   input  bus_cmd_t         sn_cmd,
   input  logic [TAG_W-1:0] sn_tag,
   input  line_st_t         line_st,
   input  logic [TAG_W-1:0] line_tag,
   output logic             sn_shared,
   output logic             sn_flush,
   output logic             sn_upd,
   output line_st_t         sn_nxt
);
   logic sn_hit;

   assign sn_hit = sn_valid && (line_st != LN_I) && (line_tag == sn_tag);

   always_comb begin
      unique case (sn_cmd)
         CMD_RD:  sn_nxt = LN_S;
         CMD_RDX: sn_nxt = LN_I;
         CMD_UPG: sn_nxt = LN_I;
         default: sn_nxt = line_st;
      endcase
   end

   assign sn_shared = sn_hit && (sn_cmd == CMD_RD);
   assign sn_flush  = sn_hit && (line_st == LN_M) &&
                      ((sn_cmd == CMD_RD) || (sn_cmd == CMD_RDX));
   assign sn_upd    = sn_hit && (sn_nxt != line_st);

endmodule

// File: rtl/mesi_miss_seq.sv
module mesi_miss_seq
   import mesi_pkg::*;
#(
   parameter int TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req_valid,
   input  logic             cpu_req_we,
   input  logic [TAG_W-1:0] cpu_tag,
   input  line_st_t         line_st,
   input  logic [TAG_W-1:0] line_tag,
   input  logic             collide,
   input  logic             snoop_kill,
   input  logic             bus_grant,
   input  logic             bus_data_valid,
   input  logic             bus_shared_in,
   output logic             cpu_ready,
   output logic             req_valid,
   output bus_cmd_t         req_cmd,
   output logic             req_victim,
   output logic             fw_en,
   output logic [TAG_W-1:0] fw_tag,
   output line_st_t         fw_st
);
   seq_st_t  seq_q, seq_d;
   bus_cmd_t cmd_q, cmd_d;
   logic     hit;
   bus_cmd_t fill_cmd;

   assign hit      = (line_st != LN_I) && (line_tag == cpu_tag);
   assign fill_cmd = cpu_req_we ? CMD_RDX : CMD_RD;

   always_comb begin
      seq_d     = seq_q;
      cmd_d     = cmd_q;
      cpu_ready = 1'b0;
      fw_en     = 1'b0;
      fw_st     = LN_I;
      fw_tag    = cpu_tag;
      unique case (seq_q)
         SQ_IDLE: begin
            if (cpu_req_valid && !collide) begin
               if (hit) begin
                  if (cpu_req_we && (line_st == LN_S)) begin
                     cmd_d = CMD_UPG;
                     seq_d = SQ_REQ;
                  end else begin
                     cpu_ready = 1'b1;
                     if (cpu_req_we && (line_st == LN_E)) begin
                        fw_en = 1'b1;
                        fw_st = LN_M;
                     end
                  end
               end else begin
                  seq_d = SQ_REQ;
                  cmd_d = (line_st == LN_M) ? CMD_WB : fill_cmd;
               end
            end
         end
         SQ_REQ: begin
            if (snoop_kill && (cmd_q == CMD_UPG)) begin
               cmd_d = CMD_RDX;
            end else if (bus_grant) begin
               if (cmd_q == CMD_UPG) begin
                  fw_en     = 1'b1;
                  fw_st     = LN_M;
                  cpu_ready = 1'b1;
                  seq_d     = SQ_IDLE;
               end else begin
                  seq_d = SQ_DATA;
               end
            end
         end
         SQ_DATA: begin
            if (bus_data_valid) begin
               fw_en = 1'b1;
               if (cmd_q == CMD_WB) begin
                  fw_st  = LN_I;
                  fw_tag = line_tag;
                  cmd_d  = fill_cmd;
                  seq_d  = SQ_REQ;
               end else begin
                  fw_st     = (cmd_q == CMD_RDX) ? LN_M :
                              (bus_shared_in ? LN_S : LN_E);
                  cpu_ready = 1'b1;
                  seq_d     = SQ_IDLE;
               end
            end
         end
         default: seq_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= SQ_IDLE;
         cmd_q <= CMD_RD;
      end else begin
         seq_q <= seq_d;
         cmd_q <= cmd_d;
      end
   end

   assign req_valid  = (seq_q == SQ_REQ);
   assign req_cmd    = cmd_q;
   assign req_victim = (cmd_q == CMD_WB);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int INDEX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_we,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_ready,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_grant,
   input  logic              bus_data_valid,
   input  logic              bus_shared_in,
   input  logic              snoop_valid,
   input  logic [1:0]        snoop_cmd,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              snoop_shared,
   output logic              snoop_flush
);
   localparam int TAG_W = ADDR_W - INDEX_W;

   if (INDEX_W < 1 || INDEX_W > 10) begin : g_bad_index
      $error("mesi_line_ctrl: INDEX_W must lie in 1..10");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("mesi_line_ctrl: ADDR_W must exceed INDEX_W");
   end

   logic [INDEX_W-1:0] cpu_idx, sn_idx;
   logic [TAG_W-1:0]   cpu_tag, sn_tag;
   line_st_t           cpu_line_st, sn_line_st;
   logic [TAG_W-1:0]   cpu_line_tag, sn_line_tag;
   logic               sn_upd;
   line_st_t           sn_nxt;
   logic               collide, snoop_kill;
   logic               fw_en;
   logic [TAG_W-1:0]   fw_tag;
   line_st_t           fw_st;
   bus_cmd_t           req_cmd;
   logic               req_victim;

   assign cpu_idx = cpu_req_addr[INDEX_W-1:0];
   assign cpu_tag = cpu_req_addr[ADDR_W-1:INDEX_W];
   assign sn_idx  = snoop_addr[INDEX_W-1:0];
   assign sn_tag  = snoop_addr[ADDR_W-1:INDEX_W];

   assign collide    = snoop_valid && (sn_idx == cpu_idx);
   assign snoop_kill = sn_upd && (sn_idx == cpu_idx) && (sn_nxt == LN_I);

   mesi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (cpu_idx),
      .rd_a_st  (cpu_line_st),
      .rd_a_tag (cpu_line_tag),
      .rd_b_idx (sn_idx),
      .rd_b_st  (sn_line_st),
      .rd_b_tag (sn_line_tag),
      .fw_en    (fw_en),
      .fw_idx   (cpu_idx),
      .fw_tag   (fw_tag),
      .fw_st    (fw_st),
      .sw_en    (sn_upd),
      .sw_idx   (sn_idx),
      .sw_st    (sn_nxt)
   );

   mesi_snoop_unit #(.TAG_W(TAG_W)) snoop_i (
      .sn_valid  (snoop_valid),
      .sn_cmd    (bus_cmd_t'(snoop_cmd)),
      .sn_tag    (sn_tag),
      .line_st   (sn_line_st),
      .line_tag  (sn_line_tag),
      .sn_shared (snoop_shared),
      .sn_flush  (snoop_flush),
      .sn_upd    (sn_upd),
      .sn_nxt    (sn_nxt)
   );

   mesi_miss_seq #(.TAG_W(TAG_W)) seq_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req_valid  (cpu_req_valid),
      .cpu_req_we     (cpu_req_we),
      .cpu_tag        (cpu_tag),
      .line_st        (cpu_line_st),
      .line_tag       (cpu_line_tag),
      .collide        (collide),
      .snoop_kill     (snoop_kill),
      .bus_grant      (bus_grant),
      .bus_data_valid (bus_data_valid),
      .bus_shared_in  (bus_shared_in),
      .cpu_ready      (cpu_ready),
      .req_valid      (bus_req_valid),
      .req_cmd        (req_cmd),
      .req_victim     (req_victim),
      .fw_en          (fw_en),
      .fw_tag         (fw_tag),
      .fw_st          (fw_st)
   );

   assign bus_req_cmd  = req_cmd;
   assign bus_req_addr = req_victim ? {cpu_line_tag, cpu_idx} : cpu_req_addr;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int ADDR_W  = 16,
   parameter int INDEX_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic [ADDR_W-1:0] cpu_req_addr,
   input logic              cpu_ready,
   input logic              bus_req_valid,
   input logic [1:0]        bus_req_cmd,
   input logic              bus_grant,
   input logic              bus_data_valid,
   input logic              snoop_valid,
   input logic [1:0]        snoop_cmd,
   input logic [ADDR_W-1:0] snoop_addr,
   input logic              snoop_shared,
   input logic              snoop_flush
);
   logic same_idx;
   assign same_idx = (cpu_req_addr[INDEX_W-1:0] == snoop_addr[INDEX_W-1:0]);

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !bus_req_valid);

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_grant && !snoop_valid) |=>
         (bus_req_valid && $stable(bus_req_cmd)));

   p_upgrade_on_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_cmd == 2'd2 && bus_grant && !snoop_valid) |-> cpu_ready);

   p_flush_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_flush |-> (snoop_valid && (snoop_cmd == 2'd0 || snoop_cmd == 2'd1)));

   p_shared_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_shared |-> (snoop_valid && snoop_cmd == 2'd0));

   p_wb_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_cmd == 2'd3) |-> !cpu_ready);

   p_collide_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && snoop_valid && same_idx && !bus_req_valid && !bus_data_valid)
         |-> !cpu_ready);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req_valid  (cpu_req_valid),
   .cpu_req_addr   (cpu_req_addr),
   .cpu_ready      (cpu_ready),
   .bus_req_valid  (bus_req_valid),
   .bus_req_cmd    (bus_req_cmd),
   .bus_grant      (bus_grant),
   .bus_data_valid (bus_data_valid),
   .snoop_valid    (snoop_valid),
   .snoop_cmd      (snoop_cmd),
   .snoop_addr     (snoop_addr),
   .snoop_shared   (snoop_shared),
   .snoop_flush    (snoop_flush)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;

   localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SN = 2'd2;
   localparam int NV = 22;

   // {req[33:30], kind[29:28], addr[27:12], arg[11:10], exp[9:0]}
   // cpu exp = {ncmds, cmd0, cmd1, 4'b0}; snoop exp = {8'b0, shared, flush}
   localparam logic [33:0] VEC [NV] = '{
      {4'd2, K_RD, 16'h0010, 2'd0,  10'b01_00_00_0000}, // R2 miss, no sharer -> E
      {4'd6, K_RD, 16'h0010, 2'd0,  10'b00_00_00_0000}, // R6 read hit
      {4'd5, K_WR, 16'h0010, 2'd0,  10'b00_00_00_0000}, // R5 silent E->M
      {4'd7, K_SN, 16'h0010, C_RD,  10'b00000000_11},   // R7 M snoops READ -> S
      {4'd8, K_SN, 16'h0010, C_RD,  10'b00000000_10},   // R8 S stays S
      {4'd4, K_WR, 16'h0010, 2'd0,  10'b01_10_00_0000}, // R4 upgrade S->M
      {4'd7, K_SN, 16'h0010, C_RDX, 10'b00000000_01},   // R7 M snoops READX -> I
      {4'd8, K_SN, 16'h0010, C_RD,  10'b00000000_00},   // R8 invalid line silent
      {4'd2, K_RD, 16'h0021, 2'd1,  10'b01_00_00_0000}, // R2 sharer -> S
      {4'd8, K_SN, 16'h0021, C_UPG, 10'b00000000_00},   // R8 S snoops UPGR -> I
      {4'd8, K_RD, 16'h0021, 2'd0,  10'b01_00_00_0000}, // R8 proves I: miss -> E
      {4'd8, K_SN, 16'h0021, C_RDX, 10'b00000000_00},   // R8 E snoops READX -> I, no flush
      {4'd3, K_WR, 16'h0010, 2'd0,  10'b01_01_00_0000}, // R3 write miss READX
      {4'd9, K_WR, 16'h0018, 2'd0,  10'b10_11_01_0000}, // R9 dirty victim: WB then READX
      {4'd9, K_SN, 16'h0010, C_RD,  10'b00000000_00},   // R9 old line gone
      {4'd7, K_SN, 16'h0018, C_RD,  10'b00000000_11},   // R7 new line M -> S
      {4'd9, K_RD, 16'h0010, 2'd1,  10'b01_00_00_0000}, // R9 clean victim silent
      {4'd8, K_SN, 16'h0010, C_WB,  10'b00000000_00},   // R8 snooped WRBACK ignored
      {4'd8, K_SN, 16'h0010, C_RD,  10'b00000000_10},   // R8 still S
      {4'd4, K_WR, 16'h0010, 2'd0,  10'b01_10_00_0000}, // R4 upgrade
      {4'd5, K_WR, 16'h0010, 2'd0,  10'b00_00_00_0000}, // R5 write hit M
      {4'd7, K_SN, 16'h0010, C_RD,  10'b00000000_11}    // R7 -> S
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
   logic [15:0] cpu_req_addr = '0;
   logic        cpu_ready;
   logic        bus_req_valid;
   logic [1:0]  bus_req_cmd;
   logic [15:0] bus_req_addr;
   logic        bus_grant = 1'b0, bus_data_valid = 1'b0, bus_shared_in = 1'b0;
   logic        snoop_valid = 1'b0;
   logic [1:0]  snoop_cmd = '0;
   logic [15:0] snoop_addr = '0;
   logic        snoop_shared, snoop_flush;

   int total = 0;
   int fails = 0;
   bit reported = 0;

   always #10 clk = ~clk;

   mesi_line_ctrl #(.ADDR_W(16), .INDEX_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
      .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready),
      .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
      .bus_req_addr(bus_req_addr), .bus_grant(bus_grant),
      .bus_data_valid(bus_data_valid), .bus_shared_in(bus_shared_in),
      .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
      .snoop_shared(snoop_shared), .snoop_flush(snoop_flush)
   );

   task automatic check(input bit ok, input int rq, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", total - fails, total);
      end
      $finish;
   endtask

   task automatic cpu_op(input logic we, input logic [15:0] a, input logic sh,
                         output int n, output logic [1:0] c0, output logic [1:0] c1,
                         output logic [15:0] fa, output bit done);
      n = 0; c0 = '0; c1 = '0; fa = '0; done = 0;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; bus_shared_in = sh;
      for (int k = 0; k < 40 && !done; k++) begin
         if (k > 0) begin
            @(negedge clk);
            bus_grant = 1'b0; bus_data_valid = 1'b0;
         end
         #5;
         if (cpu_ready) done = 1;
         else if (bus_req_valid) begin
            if (n == 0) begin c0 = bus_req_cmd; fa = bus_req_addr; end
            else c1 = bus_req_cmd;
            n++;
            bus_grant = 1'b1;
            #1;
            if (cpu_ready) done = 1;
         end else begin
            bus_data_valid = 1'b1;
            #1;
            if (cpu_ready) done = 1;
         end
      end
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
      bus_grant = 1'b0; bus_data_valid = 1'b0;
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [15:0] a,
                        output logic sh, output logic fl);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = cmd; snoop_addr = a;
      #5;
      sh = snoop_shared; fl = snoop_flush;
      @(negedge clk);
      snoop_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [33:0] v;
      int          n;
      logic [1:0]  c0, c1;
      logic [15:0] fa;
      bit          done;
      logic        sh, fl;

      repeat (3) @(posedge clk);
      #1;
      // R1: idle outputs during and after reset
      check(bus_req_valid == 1'b0, 1, "bus request in reset", bus_req_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      snoop(C_RD, 16'h0010, sh, fl);
      check(sh == 1'b0 && fl == 1'b0, 1, "snoop response after reset", {sh, fl}, 0);
      check(bus_req_valid == 1'b0, 1, "bus request after reset", bus_req_valid, 0);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         if (v[29:28] == K_SN) begin
            snoop(v[11:10], v[27:12], sh, fl);
            check({sh, fl} == v[1:0], int'(v[33:30]), $sformatf("snoop step %0d {shared,flush}", i),
                  {sh, fl}, v[1:0]);
         end else begin
            cpu_op(v[28], v[27:12], v[10], n, c0, c1, fa, done);
            check(done, int'(v[33:30]), $sformatf("cpu step %0d completion", i), done, 1);
            check(n == int'(v[9:8]), int'(v[33:30]), $sformatf("cpu step %0d command count", i),
                  n, v[9:8]);
            if (v[9:8] != 2'd0)
               check(c0 == v[7:6], int'(v[33:30]), $sformatf("cpu step %0d first command", i),
                     c0, v[7:6]);
            if (v[9:8] == 2'd2) begin
               check(c1 == v[5:4], int'(v[33:30]), $sformatf("cpu step %0d second command", i),
                     c1, v[5:4]);
               // R9: writeback carries the victim (index 0, tag 2) address
               check(fa == 16'h0010, 9, "writeback address", fa, 16'h0010);
            end
         end
      end

      // R10: cpu write and snoop on the same index in one cycle; line is S
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = 16'h0010;
      snoop_valid = 1'b1; snoop_cmd = C_RD; snoop_addr = 16'h0010;
      #5;
      check(cpu_ready == 1'b0, 10, "collision stall ready", cpu_ready, 0);
      check(snoop_shared == 1'b1, 8, "snoop shared during collision", snoop_shared, 1);
      @(negedge clk);
      snoop_valid = 1'b0;
      #5;
      check(bus_req_valid == 1'b0, 10, "no command started by stalled request", bus_req_valid, 0);
      @(negedge clk);
      #5;
      check(bus_req_valid && bus_req_cmd == C_UPG, 4, "upgrade issued", {bus_req_valid, bus_req_cmd}, 6);
      @(negedge clk);
      #5;
      // R6: request held without grant
      check(bus_req_valid && bus_req_cmd == C_UPG && !cpu_ready, 6, "request held until grant",
            {bus_req_valid, bus_req_cmd}, 6);
      // R11: a competing READX invalidates the line before grant
      snoop_valid = 1'b1; snoop_cmd = C_RDX; snoop_addr = 16'h0010;
      #1;
      check(snoop_flush == 1'b0, 8, "S line snooping READX flush", snoop_flush, 0);
      @(negedge clk);
      snoop_valid = 1'b0;
      #5;
      check(bus_req_valid && bus_req_cmd == C_RDX, 11, "lost upgrade becomes READX",
            {bus_req_valid, bus_req_cmd}, 5);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0; bus_shared_in = 1'b0;
      #5;
      check(cpu_ready == 1'b0, 11, "ready waits for data", cpu_ready, 0);
      bus_data_valid = 1'b1;
      #1;
      check(cpu_ready == 1'b1, 11, "ready at data valid", cpu_ready, 1);
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_we = 1'b0; bus_data_valid = 1'b0;
      snoop(C_RD, 16'h0010, sh, fl);
      check({sh, fl} == 2'b11, 11, "line Modified after refetch", {sh, fl}, 3);

      report();
   end

endmodule